// File: doc/BRIEF.md
# Comma-aligned word deserializer

This block sits behind an already recovered bit clock. It collects a serial stream one bit per cycle and cuts it into 10-bit words carrying 8B/10B symbols. The word boundary is unknown at start-up. When a comma symbol turns up in the stream, the block moves the boundary to it. From then on, every word leaves the block on the same symbol grid as the transmitter.

Words are handed out together with a pair of byte clocks. These are derived in the bit-clock domain, and each runs at half the word rate. One clock is always the inverse of the other. Each new word appears at a rising edge of one of the two clocks, and the next word appears at a rising edge of the other.

A select input lets the block take its bits from a local transmit stream instead of the line input. This is used for loopback testing.

Top module: `comma_deser`

## Requirements
- R1: A synchronous active-high reset sets `word_out` to 0, `comma_out` and `aligned_out` low, `rbc0` low and `rbc1` high, and clears the word-boundary state.
- R2: Bits are assembled least significant first: the first-received bit of a word lands in `word_out[0]`, the tenth in `word_out[9]`.
- R3: A comma is recognised when the seven earliest bits of a 10-bit window, in arrival order, are 0,0,1,1,1,1,1 (vector value `7'b1111100` on bits 6..0) or 1,1,0,0,0,0,0 (`7'b0000011`).
- R4: A comma found off the current boundary ends a word at once with the whole comma symbol. The following words start directly after it.
- R5: `comma_out` is high exactly with a presented word that holds a comma, and never while `aligned_out` is low.
- R6: `aligned_out` is low until the comma word is presented. It is high from that word on, until reset.
- R7: `rbc1` is always the complement of `rbc0`.
- R8: Each byte clock changes level every 10 bit-clock cycles, counted from reset, whatever the realignment does.
- R9: `word_out`, `comma_out` and `aligned_out` change only at edges where the byte clocks toggle. Each such edge presents the word most recently completed before that edge.
- R10: With `loop_sel` high, bits come from `loop_tx` and `ser_in` has no effect. With `loop_sel` low, the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Line serial input |
| loop_tx | input | 1 | Local transmit serial stream for loopback |
| loop_sel | input | 1 | High selects `loop_tx` as the source |
| word_out | output | WORD_W | Presented parallel word, bit 0 received first |
| comma_out | output | 1 | Presented word holds a comma |
| aligned_out | output | 1 | Boundary has been set by a comma |
| rbc0 | output | 1 | Receive byte clock, phase 0 |
| rbc1 | output | 1 | Receive byte clock, phase 1 |

## Verification
A corrupted boundary counter would show within two byte-clock periods. The presented words would come out bit-rotated, or a comma word would come out split or without its flag. A slip in the divider breaks the 10-cycle toggle spacing at its very next toggle. A stuck lock bit shows at the first presented word after the comma. The bench compares every port against a behavioural model on every bit clock. It also checks comma placement, realignment and loopback isolation through the presented word sequence.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;

   localparam int DEF_WORD_W  = 10;
   localparam int DEF_COMMA_W = 7;
   // arrival order 0,0,1,1,1,1,1 with bit 0 first
   localparam logic [6:0] DEF_COMMA_PAT = 7'b1111100;

   function automatic int pos_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/comma_deser_detect.sv
module comma_deser_detect #(
   parameter int                 COMMA_W   = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = '0,
   parameter bit                 BOTH_POL  = 1'b1
) (
   input  logic [COMMA_W-1:0] head,
   output logic               hit
);

   generate
      if (BOTH_POL) begin : g_both
         assign hit = (head == COMMA_PAT) || (head == ~COMMA_PAT);
      end else begin : g_single
         assign hit = (head == COMMA_PAT);
      end
   endgenerate

endmodule

// File: rtl/comma_deser_framer.sv
module comma_deser_framer
   import comma_deser_pkg::*;
#(
   parameter int                 WORD_W    = 10,
   parameter int                 COMMA_W   = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = '0,
   parameter bit                 BOTH_POL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_in,
   output logic [WORD_W-1:0] hold_word,
   output logic              hold_comma,
   output logic              hold_aligned
);

   localparam int            PW   = pos_bits(WORD_W);
   localparam logic [PW-1:0] LAST = PW'(WORD_W - 1);

   logic [WORD_W-1:0] win_q;
   logic [WORD_W-1:0] win_nx;
   logic [PW-1:0]     pos_q;
   logic              lock_q;
   logic              hit;
   logic              done;

   // newest bit enters at the top, oldest sits at bit 0
   assign win_nx = {bit_in, win_q[WORD_W-1:1]};

   comma_deser_detect #(
      .COMMA_W  (COMMA_W),
      .COMMA_PAT(COMMA_PAT),
      .BOTH_POL (BOTH_POL)
   ) u_detect (
      .head(win_nx[COMMA_W-1:0]),
      .hit (hit)
   );

   assign done = (pos_q == LAST) || hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q        <= '0;
         pos_q        <= '0;
         lock_q       <= 1'b0;
         hold_word    <= '0;
         hold_comma   <= 1'b0;
         hold_aligned <= 1'b0;
      end else begin
         win_q <= win_nx;
         if (done) begin
            pos_q        <= '0;
            hold_word    <= win_nx;
            hold_comma   <= hit;
            hold_aligned <= lock_q | hit;
            lock_q       <= lock_q | hit;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/comma_deser_present.sv
module comma_deser_present
   import comma_deser_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] hold_word,
   input  logic              hold_comma,
   input  logic              hold_aligned,
   output logic [WORD_W-1:0] word_q,
   output logic              comma_q,
   output logic              aligned_q,
   output logic              rbc0_q,
   output logic              rbc1_q
);

   localparam int            PW   = pos_bits(WORD_W);
   localparam logic [PW-1:0] LAST = PW'(WORD_W - 1);

   logic [PW-1:0] div_q;
   logic          tick;

   assign tick = (div_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q     <= '0;
         word_q    <= '0;
         comma_q   <= 1'b0;
         aligned_q <= 1'b0;
         rbc0_q    <= 1'b0;
         rbc1_q    <= 1'b1;
      end else if (tick) begin
         div_q     <= '0;
         word_q    <= hold_word;
         comma_q   <= hold_comma;
         aligned_q <= hold_aligned;
         rbc0_q    <= ~rbc0_q;
         rbc1_q    <= rbc0_q;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

endmodule

// File: rtl/comma_deser.sv
module comma_deser
   import comma_deser_pkg::*;
#(
   parameter int                 WORD_W    = DEF_WORD_W,
   parameter int                 COMMA_W   = DEF_COMMA_W,
   parameter logic [COMMA_W-1:0] COMMA_PAT = DEF_COMMA_PAT,
   parameter bit                 BOTH_POL  = 1'b1
) (
   input  logic              clk_bit,
   input  logic              rst,
   input  logic              ser_in,
   input  logic              loop_tx,
   input  logic              loop_sel,
   output logic [WORD_W-1:0] word_out,
   output logic              comma_out,
   output logic              aligned_out,
   output logic              rbc0,
   output logic              rbc1
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("comma_deser: WORD_W must be at least 2");
      end
      if (COMMA_W < 2 || COMMA_W > WORD_W) begin : g_bad_comma
         $error("comma_deser: COMMA_W must lie in 2..WORD_W");
      end
   endgenerate

   logic              src_bit;
   logic [WORD_W-1:0] hold_word;
   logic              hold_comma;
   logic              hold_aligned;

   assign src_bit = loop_sel ? loop_tx : ser_in;

   comma_deser_framer #(
      .WORD_W   (WORD_W),
      .COMMA_W  (COMMA_W),
      .COMMA_PAT(COMMA_PAT),
      .BOTH_POL (BOTH_POL)
   ) u_framer (
      .clk         (clk_bit),
      .rst         (rst),
      .bit_in      (src_bit),
      .hold_word   (hold_word),
      .hold_comma  (hold_comma),
      .hold_aligned(hold_aligned)
   );

   comma_deser_present #(
      .WORD_W(WORD_W)
   ) u_present (
      .clk         (clk_bit),
      .rst         (rst),
      .hold_word   (hold_word),
      .hold_comma  (hold_comma),
      .hold_aligned(hold_aligned),
      .word_q      (word_out),
      .comma_q     (comma_out),
      .aligned_q   (aligned_out),
      .rbc0_q      (rbc0),
      .rbc1_q      (rbc1)
   );

endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk
   import comma_deser_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input logic              clk_bit,
   input logic              rst,
   input logic [WORD_W-1:0] word_out,
   input logic              comma_out,
   input logic              aligned_out,
   input logic              rbc0,
   input logic              rbc1
);

   localparam int            GW  = pos_bits(WORD_W) + 2;
   localparam logic [GW-1:0] GAP = GW'(WORD_W);

   logic [GW-1:0] gap_q;
   logic          rbc0_d;

   always_ff @(posedge clk_bit) begin
      rbc0_d <= rbc0;
      if (rst)
         gap_q <= '0;
      else if (rbc0 != rbc0_d)
         gap_q <= GW'(1);
      else if (gap_q != '1)
         gap_q <= gap_q + 1'b1;
   end

   assert_clk_opposite_R7: assert property (@(posedge clk_bit) disable iff (rst)
      rbc1 == ~rbc0);

   assert_half_rate_R8: assert property (@(posedge clk_bit) disable iff (rst)
      (rbc0 != rbc0_d) |-> (gap_q == GAP));

   assert_word_on_edge_R9: assert property (@(posedge clk_bit) disable iff (rst)
      (word_out != $past(word_out)) |-> (rbc0 != $past(rbc0)));

   assert_aligned_sticky_R6: assert property (@(posedge clk_bit) disable iff (rst)
      aligned_out |=> aligned_out);

   assert_comma_needs_lock_R5: assert property (@(posedge clk_bit) disable iff (rst)
      comma_out |-> aligned_out);

endmodule

bind comma_deser comma_deser_chk #(.WORD_W(WORD_W)) u_chk (
   .clk_bit    (clk_bit),
   .rst        (rst),
   .word_out   (word_out),
   .comma_out  (comma_out),
   .aligned_out(aligned_out),
   .rbc0       (rbc0),
   .rbc1       (rbc1)
);

// File: tb/comma_deser_bench.sv
module comma_deser_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [9:0] K_NEG = 10'h17C;  // comma symbol, 0011111 first
   localparam logic [9:0] K_POS = 10'h283;  // comma symbol, 1100000 first
   localparam logic [9:0] FILL  = 10'h2AA;  // alternating bits, no comma

   logic       clk_bit = 1'b0;
   logic       rst = 1'b1;
   logic       ser_in = 1'b0;
   logic       loop_tx = 1'b0;
   logic       loop_sel = 1'b0;
   logic [9:0] word_out;
   logic       comma_out, aligned_out, rbc0, rbc1;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

   comma_deser u_comma_deser (
      .clk_bit    (clk_bit),
      .rst        (rst),
      .ser_in     (ser_in),
      .loop_tx    (loop_tx),
      .loop_sel   (loop_sel),
      .word_out   (word_out),
      .comma_out  (comma_out),
      .aligned_out(aligned_out),
      .rbc0       (rbc0),
      .rbc1       (rbc1)
   );

   // behavioural reference
   logic [9:0] m_win, m_hw, m_w;
   logic       m_hc, m_ha, m_c, m_a, m_r0, m_lock, m_bit, m_det;
   int         m_pos, m_div;

   always @(posedge clk_bit) begin
      if (rst) begin
         m_win = '0; m_hw = '0; m_w = '0;
         m_hc = 0; m_ha = 0; m_c = 0; m_a = 0; m_r0 = 0; m_lock = 0;
         m_pos = 0; m_div = 0;
      end else begin
         m_bit = loop_sel ? loop_tx : ser_in;
         if (m_div == 9) begin
            m_w = m_hw; m_c = m_hc; m_a = m_ha; m_r0 = !m_r0; m_div = 0;
         end else m_div++;
         m_win = {m_bit, m_win[9:1]};
         m_det = (m_win[6:0] == 7'b1111100) || (m_win[6:0] == 7'b0000011);
         if (m_det) m_lock = 1;
         if (m_det || m_pos == 9) begin
            m_hw = m_win; m_hc = m_det; m_ha = m_lock; m_pos = 0;
         end else m_pos++;
      end
   end

   // presentations seen at the ports
   logic [9:0] pw[$];
   logic       pc[$];
   logic       pa[$];
   logic       seen_r0 = 0;
   logic [9:0] seen_w = '0;
   int         gap = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
      end
   endtask

   task automatic compare();
      chk(word_out == m_w, "R2", "word", word_out, m_w);
      chk(comma_out == m_c, "R5", "comma flag", comma_out, m_c);
      chk(aligned_out == m_a, "R6", "aligned", aligned_out, m_a);
      chk(rbc0 == m_r0, "R8", "rbc0", rbc0, m_r0);
      chk(rbc1 == !rbc0, "R7", "rbc1", rbc1, !rbc0);
      if (!rst) begin
         gap++;
         if (word_out != seen_w)
            chk(rbc0 != seen_r0, "R9", "word moved off toggle", rbc0, !seen_r0);
         if (rbc0 != seen_r0) begin
            chk(gap == 10, "R8", "toggle spacing", gap, 10);
            gap = 0;
            pw.push_back(word_out); pc.push_back(comma_out); pa.push_back(aligned_out);
         end
      end
      seen_r0 = rbc0;
      seen_w  = word_out;
   endtask

   task automatic step(input logic s, input logic t);
      @(negedge clk_bit);
      compare();
      ser_in = s; loop_tx = t;
   endtask

   task automatic send_word(input logic [9:0] s, input logic [9:0] t);
      for (int i = 0; i < 10; i++) step(s[i], t[i]);
   endtask

   task automatic do_reset();
      rst = 1; ser_in = 0; loop_tx = 0;
      repeat (3) @(negedge clk_bit);
      chk(word_out == 0, "R1", "reset word", word_out, 0);
      chk(comma_out == 0, "R1", "reset comma", comma_out, 0);
      chk(aligned_out == 0, "R1", "reset aligned", aligned_out, 0);
      chk(rbc0 == 0, "R1", "reset rbc0", rbc0, 0);
      chk(rbc1 == 1, "R1", "reset rbc1", rbc1, 1);
      seen_r0 = 0; seen_w = '0; gap = 0;
      pw.delete(); pc.delete(); pa.delete();
      rst = 0;
   endtask

   // find a comma word, check flags before it and the word after it
   task automatic check_comma_seq(input logic [9:0] kw, input string req);
      int idx = -1;
      for (int i = 0; i < pw.size(); i++)
         if (idx < 0 && pw[i] == kw) idx = i;
      chk(idx >= 0, req, "comma word presented", idx, 0);
      if (idx >= 0) begin
         chk(pc[idx] == 1, "R5", "flag on comma word", pc[idx], 1);
         chk(pa[idx] == 1, "R6", "aligned at comma word", pa[idx], 1);
         if (idx + 1 < pw.size()) begin
            chk(pw[idx+1] == FILL, "R4", "word after comma", pw[idx+1], FILL);
            chk(pc[idx+1] == 0, "R5", "no flag after comma", pc[idx+1], 0);
         end else chk(0, "R4", "word after comma missing", 0, 1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; failures++;
      $display("FAIL watchdog expired got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1 and R3/R4: negative-first comma four bits off the boundary
      do_reset();
      repeat (3) send_word(FILL, 0);
      step(0, 0); step(1, 0); step(0, 0); step(1, 0);
      send_word(K_NEG, 0);
      repeat (4) send_word(FILL, 0);
      for (int i = 0; i < pw.size() && pw[i] != K_NEG; i++) begin
         chk(pa[i] == 0, "R6", "aligned before comma", pa[i], 0);
         chk(pc[i] == 0, "R5", "flag before comma", pc[i], 0);
      end
      check_comma_seq(K_NEG, "R4");

      // R3: other comma polarity at a fresh offset, no reset
      pw.delete(); pc.delete(); pa.delete();
      step(0, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
      send_word(K_POS, 0);
      repeat (4) send_word(FILL, 0);
      check_comma_seq(K_POS, "R3");

      // R10: loopback ignores commas on the line input
      do_reset();
      loop_sel = 1;
      repeat (6) send_word(K_NEG, FILL);
      for (int i = 0; i < pw.size(); i++) begin
         chk(pc[i] == 0, "R10", "line comma leaked", pc[i], 0);
         chk(pa[i] == 0, "R10", "aligned from line", pa[i], 0);
      end
      pw.delete(); pc.delete(); pa.delete();
      step(1, 0); step(0, 1); step(1, 0);
      send_word(FILL, K_NEG);
      repeat (4) send_word(K_NEG, FILL);
      check_comma_seq(K_NEG, "R10");

      // mixed random traffic with commas and source switching
      do_reset();
      for (int n = 0; n < 60; n++) begin
         if (n % 15 == 0) loop_sel = $urandom_range(0, 1);
         if ($urandom_range(0, 5) == 0)
            send_word(($urandom_range(0, 1) != 0) ? K_NEG : K_POS, 10'($urandom));
         else
            for (int b = 0; b < $urandom_range(3, 12); b++)
               step(1'($urandom), 1'($urandom));
      end
      repeat (25) step(0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule